// File: doc/BRIEF.md
# Segment Descriptor Cache Loader

This block keeps the hidden per-segment state that a processor core consults on every memory reference: a 32-bit base, a 32-bit byte limit and an access-rights word for each of six segment registers. Each load of a segment register rewrites one entry. The state is computed once, at load time, so later address checks never need to fetch descriptors again.

A mode input selects real or protected behaviour. A real-mode load computes only the base, as the selector shifted left by four bits. The limit and rights already in the entry are kept, so a 4 GB limit set up under protected mode stays in effect after a return to real mode. A protected-mode load takes the whole entry from a 64-bit descriptor on an input port. It checks the descriptor first and reports a fault code when the check fails. A core-style input chooses between two behaviours:
- In legacy style, the code segment is restored to real-mode limit and rights on real-mode loads and on far transfers, and the privilege level is read from the stack segment's rights.
- In newer style, the code-segment state is left alone, and a separate privilege register is used.

All six entries and the current privilege level are outputs.

Top module: `segcache_unit`

## Requirements
- R1: After reset, every entry holds base 0x00000000, limit 0x0000FFFF and rights 0x093, the current privilege level is 0 and the fault code is 0. Segment index encoding: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS.
- R2: A real-mode load (prot_mode_i=0) of any index sets that entry's base to the 16-bit selector multiplied by 16, zero-extended to 32 bits.
- R3: A real-mode load of any non-CS index leaves that entry's limit and rights unchanged, including a 0xFFFFFFFF limit left by an earlier protected-mode load.
- R4: With legacy_core_i=1, a real-mode CS load or a far_xfer_i pulse in real mode sets the CS limit to 0x0000FFFF and the CS rights to 0x093, and a far transfer leaves the CS base unchanged. With legacy_core_i=0, both leave the CS limit and rights unchanged.
- R5: A protected-mode load without a fault replaces base, limit and rights together. The base is descriptor bits {63:56, 39:16}. The 20-bit limit is descriptor bits {51:48, 15:0}.
- R6: The rights word is 11 bits. From bit 10 down to bit 0 it holds G (desc bit 55), D/B (54), AVL (52), P (47), DPL (46:45), S (44) and type (43:40). When G=1 the stored limit is limit20*4096+0xFFF. When G=0 it is limit20 zero-extended.
- R7: A protected-mode load raises fault code 1 (type mismatch) in two cases: loading CS with a descriptor that is not executable (S=1 and type bit 3 = 1 means executable), or loading any other index with an executable descriptor. The entry is not updated.
- R8: A protected-mode load that passes the type check but has P=0 raises fault code 2 (not present), and the entry is not updated. When both checks fail, code 1 is reported.
- R9: With legacy_core_i=1, cpl_o equals the DPL held in the SS entry. With legacy_core_i=0, cpl_o is a separate register. It is written with the descriptor DPL only by a successful protected-mode SS load made while legacy_core_i=0, and it holds its value through every other event.
- R10: Loads and fault codes appear on the outputs one clock after the load strobe, and the fault code returns to 0 on the following cycle when no new load faults. Index values 6 and 7 change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid_i | input | 1 | Segment register load strobe |
| ld_idx_i | input | 3 | Index of the segment being loaded |
| prot_mode_i | input | 1 | 1 selects protected-mode load behaviour |
| sel_i | input | 16 | Selector value used by real-mode loads |
| desc_i | input | 64 | Descriptor used by protected-mode loads |
| far_xfer_i | input | 1 | Far control transfer pulse |
| legacy_core_i | input | 1 | 1 selects legacy code-segment and privilege behaviour |
| seg_base_o | output | 192 | Six 32-bit bases, entry i at bits i*32 +: 32 |
| seg_limit_o | output | 192 | Six 32-bit byte limits, entry i at bits i*32 +: 32 |
| seg_rights_o | output | 66 | Six 11-bit rights words, entry i at bits i*11 +: 11 |
| fault_code_o | output | 2 | 0 none, 1 type mismatch, 2 not present |
| cpl_o | output | 2 | Current privilege level |

## Verification
The bench targets the unreal-mode case. A real-mode load after a 4 GB protected load must keep the expanded limit; a design that resets the limit would show 0x0000FFFF there. It loads CS with an invalid descriptor in both mismatch directions and with a non-present descriptor. A design that wrote the entry anyway, or that reversed the priority between the two fault codes, would show a changed entry or the wrong code. It compares the two core styles on real-mode CS loads, far transfers and SS-derived privilege, which exposes a missing or inverted style select. It also drives an out-of-range index and checks the G=0 and G=1 limit expansion.

// File: rtl/segcache_pkg.sv
package segcache_pkg;
  localparam int SEG_CNT  = 6;
  localparam int IDX_W    = 3;
  localparam int SEL_W    = 16;
  localparam int ADDR_W   = 32;
  localparam int RIGHTS_W = 11;
  localparam int DESC_W   = 64;

  localparam logic [IDX_W-1:0] IDX_CS = 3'd1;
  localparam logic [IDX_W-1:0] IDX_SS = 3'd2;

  localparam logic [RIGHTS_W-1:0] RM_RIGHTS = 11'h093;
  localparam logic [ADDR_W-1:0]   RM_LIMIT  = 32'h0000_FFFF;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_TYPE = 2'd1,
    FLT_NP   = 2'd2
  } flt_e;

  function automatic logic [ADDR_W-1:0] rm_base(input logic [SEL_W-1:0] sel);
    return {{(ADDR_W-SEL_W-4){1'b0}}, sel, 4'b0000};
  endfunction

  function automatic logic [ADDR_W-1:0] desc_base(input logic [DESC_W-1:0] d);
    return {d[63:56], d[39:16]};
  endfunction

  function automatic logic [ADDR_W-1:0] desc_limit(input logic [DESC_W-1:0] d);
    logic [19:0] raw;
    raw = {d[51:48], d[15:0]};
    if (d[55]) return {raw, 12'hFFF};
    return {12'h000, raw};
  endfunction

  function automatic logic [RIGHTS_W-1:0] desc_rights(input logic [DESC_W-1:0] d);
    return {d[55], d[54], d[52], d[47], d[46:45], d[44], d[43:40]};
  endfunction

  function automatic logic desc_exec(input logic [DESC_W-1:0] d);
    return d[44] & d[43];
  endfunction
endpackage

// File: rtl/segcache_decode.sv
module segcache_decode
  import segcache_pkg::*;
(
  input  logic [DESC_W-1:0]   desc_i,
  input  logic                is_cs_i,
  output logic [ADDR_W-1:0]   base_o,
  output logic [ADDR_W-1:0]   limit_o,
  output logic [RIGHTS_W-1:0] rights_o,
  output flt_e                flt_o
);
  logic exec_w;
  logic present_w;

  assign exec_w    = desc_exec(desc_i);
  assign present_w = desc_i[47];
  assign base_o    = desc_base(desc_i);
  assign limit_o   = desc_limit(desc_i);
  assign rights_o  = desc_rights(desc_i);

  always_comb begin
    if (is_cs_i ? !exec_w : exec_w) flt_o = FLT_TYPE;
    else if (!present_w)            flt_o = FLT_NP;
    else                            flt_o = FLT_NONE;
  end
endmodule

// File: rtl/segcache_entry.sv
module segcache_entry
  import segcache_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int RW = RIGHTS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_full_i,
  input  logic          ld_base_i,
  input  logic          rm_attr_i,
  input  logic [AW-1:0] full_base_i,
  input  logic [AW-1:0] full_limit_i,
  input  logic [RW-1:0] full_rights_i,
  input  logic [AW-1:0] rm_base_i,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] limit_o,
  output logic [RW-1:0] rights_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_o   <= '0;
      limit_o  <= AW'(RM_LIMIT);
      rights_o <= RW'(RM_RIGHTS);
    end else if (ld_full_i) begin
      base_o   <= full_base_i;
      limit_o  <= full_limit_i;
      rights_o <= full_rights_i;
    end else begin
      if (ld_base_i) base_o <= rm_base_i;
      if (rm_attr_i) begin
        limit_o  <= AW'(RM_LIMIT);
        rights_o <= RW'(RM_RIGHTS);
      end
    end
  end

  // R3
  keep_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_base_i && !rm_attr_i && !ld_full_i) |=> ($stable(limit_o) && $stable(rights_o)));

  // R4
  rm_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_attr_i && !ld_full_i) |=> (limit_o == AW'(RM_LIMIT) && rights_o == RW'(RM_RIGHTS)));
endmodule

// File: rtl/segcache_priv.sv
module segcache_priv (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       legacy_i,
  input  logic [1:0] ss_dpl_i,
  input  logic       pm_ss_load_i,
  input  logic [1:0] new_dpl_i,
  output logic [1:0] cpl_o
);
  logic [1:0] cpl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cpl_q <= 2'd0;
    else if (pm_ss_load_i) cpl_q <= new_dpl_i;
  end

  assign cpl_o = legacy_i ? ss_dpl_i : cpl_q;

  // R9
  cpl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pm_ss_load_i |=> $stable(cpl_q));
endmodule

// File: rtl/segcache_unit.sv
module segcache_unit
  import segcache_pkg::*;
#(
  parameter int N_SEG = SEG_CNT,
  parameter int IW    = IDX_W,
  parameter int SW    = SEL_W,
  parameter int AW    = ADDR_W,
  parameter int RW    = RIGHTS_W,
  parameter int DW    = DESC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid_i,
  input  logic [IW-1:0]     ld_idx_i,
  input  logic              prot_mode_i,
  input  logic [SW-1:0]     sel_i,
  input  logic [DW-1:0]     desc_i,
  input  logic              far_xfer_i,
  input  logic              legacy_core_i,
  output logic [N_SEG*AW-1:0] seg_base_o,
  output logic [N_SEG*AW-1:0] seg_limit_o,
  output logic [N_SEG*RW-1:0] seg_rights_o,
  output logic [1:0]        fault_code_o,
  output logic [1:0]        cpl_o
);
  localparam int SS_POS = int'(IDX_SS);

  logic [AW-1:0] dec_base_w, dec_limit_w, rm_base_w;
  logic [RW-1:0] dec_rights_w;
  flt_e          dec_flt_w;
  logic          idx_ok_w;
  logic          pm_load_w;
  logic          pm_fault_w;
  logic          pm_ok_w;
  logic          rm_load_w;
  logic [N_SEG-1:0] hit_w;
  logic [1:0]    fault_q;

  assign idx_ok_w   = (int'(ld_idx_i) < N_SEG);
  assign pm_load_w  = ld_valid_i && prot_mode_i && idx_ok_w;
  assign rm_load_w  = ld_valid_i && !prot_mode_i;
  assign pm_fault_w = pm_load_w && (dec_flt_w != FLT_NONE);
  assign pm_ok_w    = pm_load_w && (dec_flt_w == FLT_NONE);
  assign rm_base_w  = rm_base(sel_i);

  segcache_decode u_decode (
    .desc_i   (desc_i),
    .is_cs_i  (ld_idx_i == IDX_CS),
    .base_o   (dec_base_w),
    .limit_o  (dec_limit_w),
    .rights_o (dec_rights_w),
    .flt_o    (dec_flt_w)
  );

  for (genvar g = 0; g < N_SEG; g++) begin : g_seg
    logic ld_full_w, ld_base_w, rm_attr_w;
    assign hit_w[g]   = ld_valid_i && (int'(ld_idx_i) == g);
    assign ld_full_w  = hit_w[g] && pm_ok_w;
    assign ld_base_w  = hit_w[g] && rm_load_w;
    if (g == int'(IDX_CS)) begin : g_cs
      assign rm_attr_w = legacy_core_i && !prot_mode_i && (ld_base_w || far_xfer_i);
    end else begin : g_data
      assign rm_attr_w = 1'b0;
    end

    segcache_entry #(.AW(AW), .RW(RW)) u_entry (
      .clk          (clk),
      .rst_n        (rst_n),
      .ld_full_i    (ld_full_w),
      .ld_base_i    (ld_base_w),
      .rm_attr_i    (rm_attr_w),
      .full_base_i  (dec_base_w),
      .full_limit_i (dec_limit_w),
      .full_rights_i(dec_rights_w),
      .rm_base_i    (rm_base_w),
      .base_o       (seg_base_o[g*AW +: AW]),
      .limit_o      (seg_limit_o[g*AW +: AW]),
      .rights_o     (seg_rights_o[g*RW +: RW])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          fault_q <= FLT_NONE;
    else if (pm_fault_w) fault_q <= dec_flt_w;
    else                 fault_q <= FLT_NONE;
  end
  assign fault_code_o = fault_q;

  segcache_priv u_priv (
    .clk          (clk),
    .rst_n        (rst_n),
    .legacy_i     (legacy_core_i),
    .ss_dpl_i     (seg_rights_o[SS_POS*RW + 5 +: 2]),
    .pm_ss_load_i (hit_w[SS_POS] && pm_ok_w && !legacy_core_i),
    .new_dpl_i    (dec_rights_w[6:5]),
    .cpl_o        (cpl_o)
  );

  // R7
  fault_noupd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pm_fault_w |=> (fault_code_o != 2'd0 && $stable(seg_base_o) &&
                    $stable(seg_limit_o) && $stable(seg_rights_o)));

  // R10
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pm_fault_w |=> (fault_code_o == 2'd0));

  // R10
  bad_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid_i && !idx_ok_w && !far_xfer_i) |=> ($stable(seg_base_o) &&
      $stable(seg_limit_o) && $stable(seg_rights_o)));
endmodule

// File: tb/segcache_unit_bench.sv
module segcache_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0;
  logic [2:0] ld_idx = '0;
  logic prot = 1'b0;
  logic [15:0] sel = '0;
  logic [63:0] desc = '0;
  logic far_x = 1'b0;
  logic legacy = 1'b1;
  logic [191:0] bases, limits;
  logic [65:0] rights;
  logic [1:0] fcode, cpl;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  segcache_unit u_segcache_unit (
    .clk(clk), .rst_n(rst_n), .ld_valid_i(ld_valid), .ld_idx_i(ld_idx),
    .prot_mode_i(prot), .sel_i(sel), .desc_i(desc), .far_xfer_i(far_x),
    .legacy_core_i(legacy), .seg_base_o(bases), .seg_limit_o(limits),
    .seg_rights_o(rights), .fault_code_o(fcode), .cpl_o(cpl)
  );

  function automatic logic [31:0] base_of(input int i);  return bases[i*32 +: 32];  endfunction
  function automatic logic [31:0] lim_of(input int i);   return limits[i*32 +: 32]; endfunction
  function automatic logic [10:0] rts_of(input int i);   return rights[i*11 +: 11]; endfunction

  function automatic logic [63:0] mk(input logic [31:0] b, input logic [19:0] l, input logic g,
      input logic db, input logic avl, input logic p, input logic [1:0] dpl,
      input logic s, input logic [3:0] ty);
    logic [63:0] d;
    d = '0;
    d[63:56] = b[31:24]; d[39:16] = b[23:0];
    d[51:48] = l[19:16]; d[15:0] = l[15:0];
    d[55] = g; d[54] = db; d[52] = avl; d[47] = p; d[46:45] = dpl; d[44] = s; d[43:40] = ty;
    return d;
  endfunction

  function automatic logic [10:0] exp_rts(input logic g, input logic db, input logic avl,
      input logic p, input logic [1:0] dpl, input logic s, input logic [3:0] ty);
    return {g, db, avl, p, dpl, s, ty};
  endfunction

  function automatic logic [31:0] exp_lim(input logic [19:0] l, input logic g);
    return g ? (32'(l) * 32'd4096 + 32'hFFF) : 32'(l);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_ld(input logic [2:0] idx, input logic pm, input logic [15:0] s,
                       input logic [63:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_idx = idx; prot = pm; sel = s; desc = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic do_far(input logic pm);
    @(negedge clk);
    far_x = 1'b1; prot = pm;
    @(negedge clk);
    far_x = 1'b0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 6; i++) begin
      chk("R1 base", base_of(i), 32'h0);
      chk("R1 limit", lim_of(i), 32'hFFFF);
      chk("R1 rights", 32'(rts_of(i)), 32'h093);
    end
    chk("R1 cpl", 32'(cpl), 0);
    chk("R1 fault", 32'(fcode), 0);
  endtask

  task automatic t_real_base;
    do_ld(3'd3, 1'b0, 16'h1234, '0);
    chk("R2 R10 DS base", base_of(3), 32'h0001_2340);
    do_ld(3'd5, 1'b0, 16'hFFFF, '0);
    chk("R2 GS base", base_of(5), 32'h000F_FFF0);
    chk("R3 GS limit", lim_of(5), 32'hFFFF);
  endtask

  task automatic t_prot;
    logic [63:0] d;
    d = mk(32'h89AB_CDEF, 20'hFFFFF, 1, 1, 1, 1, 2'd2, 1, 4'h2);
    do_ld(3'd3, 1'b1, 16'h0, d);
    chk("R5 base", base_of(3), 32'h89AB_CDEF);
    chk("R6 limit G1", lim_of(3), exp_lim(20'hFFFFF, 1));
    chk("R6 rights", 32'(rts_of(3)), 32'(exp_rts(1, 1, 1, 1, 2'd2, 1, 4'h2)));
    chk("R10 fault", 32'(fcode), 0);
    d = mk(32'h0040_0000, 20'h12345, 0, 0, 0, 1, 2'd0, 1, 4'h3);
    do_ld(3'd0, 1'b1, 16'h0, d);
    chk("R6 limit G0", lim_of(0), 32'h0001_2345);
    chk("R5 ES base", base_of(0), 32'h0040_0000);
    d = mk(32'h0000_1000, 20'h00003, 1, 0, 0, 1, 2'd0, 1, 4'h2);
    do_ld(3'd4, 1'b1, 16'h0, d);
    chk("R6 limit G1 small", lim_of(4), 32'h0000_3FFF);
  endtask

  task automatic t_unreal;
    do_ld(3'd3, 1'b0, 16'h0010, '0);
    chk("R2 DS base", base_of(3), 32'h0000_0100);
    chk("R3 DS limit kept", lim_of(3), 32'hFFFF_FFFF);
    chk("R3 DS rights kept", 32'(rts_of(3)), 32'(exp_rts(1, 1, 1, 1, 2'd2, 1, 4'h2)));
  endtask

  task automatic t_faults;
    logic [31:0] b1, l1;
    logic [10:0] r1;
    b1 = base_of(1); l1 = lim_of(1); r1 = rts_of(1);
    do_ld(3'd1, 1'b1, 16'h0, mk(32'h5555_0000, 20'h1, 0, 0, 0, 1, 2'd0, 1, 4'h3));
    chk("R7 CS data code", 32'(fcode), 1);
    chk("R7 CS base kept", base_of(1), b1);
    chk("R7 CS limit kept", lim_of(1), l1);
    chk("R7 CS rights kept", 32'(rts_of(1)), 32'(r1));
    @(negedge clk);
    chk("R10 fault clears", 32'(fcode), 0);
    b1 = base_of(3);
    do_ld(3'd3, 1'b1, 16'h0, mk(32'h7777_0000, 20'h1, 0, 0, 0, 1, 2'd0, 1, 4'hA));
    chk("R7 DS exec code", 32'(fcode), 1);
    chk("R7 DS base kept", base_of(3), b1);
    b1 = base_of(4);
    do_ld(3'd4, 1'b1, 16'h0, mk(32'h6666_0000, 20'h1, 0, 0, 0, 0, 2'd0, 1, 4'h2));
    chk("R8 np code", 32'(fcode), 2);
    chk("R8 FS base kept", base_of(4), b1);
    do_ld(3'd1, 1'b1, 16'h0, mk(32'h6666_0000, 20'h1, 0, 0, 0, 0, 2'd0, 1, 4'h2));
    chk("R8 type beats np", 32'(fcode), 1);
  endtask

  task automatic t_cs_legacy;
    legacy = 1'b1;
    do_ld(3'd1, 1'b1, 16'h0, mk(32'h0010_0000, 20'hFFFFF, 1, 1, 0, 1, 2'd0, 1, 4'hA));
    chk("R5 CS limit", lim_of(1), 32'hFFFF_FFFF);
    do_ld(3'd1, 1'b0, 16'hF000, '0);
    chk("R2 CS base", base_of(1), 32'h000F_0000);
    chk("R4 legacy CS limit", lim_of(1), 32'hFFFF);
    chk("R4 legacy CS rights", 32'(rts_of(1)), 32'h093);
    do_ld(3'd1, 1'b1, 16'h0, mk(32'h0020_0000, 20'hFFFFF, 1, 1, 0, 1, 2'd0, 1, 4'hA));
    do_far(1'b0);
    chk("R4 far limit", lim_of(1), 32'hFFFF);
    chk("R4 far rights", 32'(rts_of(1)), 32'h093);
    chk("R4 far base kept", base_of(1), 32'h0020_0000);
  endtask

  task automatic t_cs_newer;
    logic [10:0] r;
    legacy = 1'b0;
    do_ld(3'd1, 1'b1, 16'h0, mk(32'h0030_0000, 20'hFFFFF, 1, 1, 0, 1, 2'd0, 1, 4'hA));
    r = exp_rts(1, 1, 0, 1, 2'd0, 1, 4'hA);
    do_ld(3'd1, 1'b0, 16'h1000, '0);
    chk("R2 CS base newer", base_of(1), 32'h0001_0000);
    chk("R4 newer CS limit kept", lim_of(1), 32'hFFFF_FFFF);
    chk("R4 newer CS rights kept", 32'(rts_of(1)), 32'(r));
    do_far(1'b0);
    chk("R4 newer far limit kept", lim_of(1), 32'hFFFF_FFFF);
    chk("R4 newer far rights kept", 32'(rts_of(1)), 32'(r));
  endtask

  task automatic t_cpl;
    legacy = 1'b1;
    do_ld(3'd2, 1'b1, 16'h0, mk(32'h0, 20'hFFFF, 0, 1, 0, 1, 2'd3, 1, 4'h3));
    chk("R9 legacy cpl from SS", 32'(cpl), 3);
    @(negedge clk); legacy = 1'b0;
    @(negedge clk);
    chk("R9 newer cpl register untouched", 32'(cpl), 0);
    do_ld(3'd2, 1'b1, 16'h0, mk(32'h0, 20'hFFFF, 0, 1, 0, 1, 2'd1, 1, 4'h3));
    chk("R9 newer cpl written", 32'(cpl), 1);
    do_ld(3'd2, 1'b0, 16'h0200, '0);
    chk("R9 real SS load keeps cpl", 32'(cpl), 1);
    do_ld(3'd2, 1'b1, 16'h0, mk(32'h0, 20'hFFFF, 0, 1, 0, 1, 2'd2, 1, 4'hB));
    chk("R9 faulted SS keeps cpl", 32'(cpl), 1);
    @(negedge clk); legacy = 1'b1;
    @(negedge clk);
    chk("R9 legacy reads SS DPL", 32'(cpl), 1);
  endtask

  task automatic t_bad_idx;
    logic [191:0] b0, l0;
    logic [65:0] r0;
    b0 = bases; l0 = limits; r0 = rights;
    do_ld(3'd7, 1'b0, 16'hABCD, '0);
    do_ld(3'd6, 1'b1, 16'h0, mk(32'h1111_1111, 20'h1, 0, 0, 0, 1, 2'd0, 1, 4'h2));
    chk("R10 idx67 bases", 32'(bases == b0), 1);
    chk("R10 idx67 limits", 32'(limits == l0), 1);
    chk("R10 idx67 rights", 32'(rights == r0), 1);
    chk("R10 idx67 fault", 32'(fcode), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_real_base();
    t_prot();
    t_unreal();
    t_faults();
    t_cs_legacy();
    t_cs_newer();
    t_cpl();
    t_bad_idx();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule